// File: doc/BRIEF.md
# Latched Parity Bus Transceiver

The block joins two 8-bit data buses, A and B, each carrying one parity bit. Data moves in one direction at a time, chosen by two active-low drive enables. Each side has a capture register, loaded on every clock when its latch enable is high and frozen when it is low. The word sent across is taken from the source side's register. Its parity bit is either computed fresh over the data bits (generate mode) or copied from the source parity bit (feed-through mode). Parity can be even or odd.

Each side has an active-low error flag. The source flag reports whether the stored source word is consistent with the selected parity. If the destination side's latch enable is also high, that register takes in the transmitted word, and the destination flag checks the word that was sent one clock later. The tri-state buses are split into separate input, output and output-enable ports for each side.

Top module: `parity_xcvr`

## Requirements
- R1: With both drive enables high, neither output enable is asserted, both data and parity outputs read zero, and both error flags are high.
- R2: With only `drv_b_n` low, the B side is driven (`b_oe`=1) with the A register's data. With only `drv_a_n` low, the A side is driven with the B register's data. The side that is not driven has its output enable low and its outputs at zero.
- R3: In generate mode (`feed_sel`=0), the driven parity bit is computed over the source register's data bits.
- R4: In feed-through mode (`feed_sel`=1), the driven parity bit equals the source register's stored parity bit.
- R5: With `odd_sel`=0, generated parity makes the count of ones across the data bits plus the parity bit even. With `odd_sel`=1, that count is odd.
- R6: A side's register loads its bus word (data and parity) at a clock edge where its latch enable is high, and is visible one cycle later. When the enable is low, the register holds.
- R7: While a side is the source, its error flag is low exactly when the stored data and stored parity bit break the selected parity. This holds in both modes.
- R8: While a side is the destination, its register loads the transmitted word when its latch enable is high. Its error flag then checks the stored word against the selected parity. When its latch enable is low, its error flag stays high.
- R9: With both drive enables low, `clash` is high, neither side is driven, and both error flags are high.
- R10: Asynchronous active-low reset clears both registers to zero data and zero parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| drv_a_n | input | 1 | Drive A bus from B side, active low |
| drv_b_n | input | 1 | Drive B bus from A side, active low |
| feed_sel | input | 1 | 0 = generate parity, 1 = pass parity through |
| odd_sel | input | 1 | 0 = even parity, 1 = odd parity |
| lat_a_en | input | 1 | A register loads while high |
| lat_b_en | input | 1 | B register loads while high |
| a_in | input | 8 | A bus data seen at the pins |
| a_par_in | input | 1 | A bus parity seen at the pins |
| a_out | output | 8 | A bus data to drive |
| a_par_out | output | 1 | A bus parity to drive |
| a_oe | output | 1 | A bus output enable |
| b_in | input | 8 | B bus data seen at the pins |
| b_par_in | input | 1 | B bus parity seen at the pins |
| b_out | output | 8 | B bus data to drive |
| b_par_out | output | 1 | B bus parity to drive |
| b_oe | output | 1 | B bus output enable |
| err_a_n | output | 1 | A side parity error, active low |
| err_b_n | output | 1 | B side parity error, active low |
| clash | output | 1 | Both drive enables low |

## Verification
The bench injects source words with deliberately wrong parity in feed-through mode. A design that regenerated parity there would hide the fault from the destination flag, and a design that never checked the source would keep the source flag high. Direction changes while a register holds stale data check that the source word comes from the register and not from the pins. A pin-fed design would show new data one cycle early. The bench also covers loopback with the destination latch enabled and disabled: a destination flag that ignored its latch enable would report errors on a word it never captured. Simultaneous drive enables must produce `clash` with no output enabled. A design that let either side win would drive a bus.

// File: rtl/parity_xcvr_pkg.sv
package parity_xcvr_pkg;
  parameter int DATA_W = 8;

  typedef struct packed {
    logic              par;
    logic [DATA_W-1:0] data;
  } word_t;

  // parity bit that makes data+bit satisfy the polarity (odd=1 -> odd count)
  function automatic logic gen_parity(logic [DATA_W-1:0] d, logic odd);
    return (^d) ^ odd;
  endfunction
endpackage

// File: rtl/parity_xcvr_route.sv
module parity_xcvr_route (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_a_n,
  input  logic drv_b_n,
  output logic dir_ab,
  output logic dir_ba,
  output logic clash
);
  assign dir_ab = drv_a_n & ~drv_b_n;
  assign dir_ba = ~drv_a_n & drv_b_n;
  assign clash  = ~drv_a_n & ~drv_b_n;

  assert_one_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dir_ab, dir_ba, clash}));
endmodule

// File: rtl/parity_xcvr_latch.sv
module parity_xcvr_latch
  import parity_xcvr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  word_t d,
  output word_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (q == $past(d)));
endmodule

// File: rtl/parity_xcvr_check.sv
module parity_xcvr_check
  import parity_xcvr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t w,
  input  logic  odd,
  output logic  gen,
  output logic  mismatch
);
  assign gen      = gen_parity(w.data, odd);
  assign mismatch = gen != w.par;

  assert_polarity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (($countones({w.data, gen}) % 2) == int'(odd)));
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
  import parity_xcvr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drv_a_n,
  input  logic              drv_b_n,
  input  logic              feed_sel,
  input  logic              odd_sel,
  input  logic              lat_a_en,
  input  logic              lat_b_en,
  input  logic [DATA_W-1:0] a_in,
  input  logic              a_par_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_par_out,
  output logic              a_oe,
  input  logic [DATA_W-1:0] b_in,
  input  logic              b_par_in,
  output logic [DATA_W-1:0] b_out,
  output logic              b_par_out,
  output logic              b_oe,
  output logic              err_a_n,
  output logic              err_b_n,
  output logic              clash
);
  localparam int SIDES = 2;

  logic dir_ab, dir_ba;
  word_t bus_in [SIDES];
  word_t reg_d  [SIDES];
  word_t reg_q  [SIDES];
  logic [SIDES-1:0] lat_en, is_src, is_dst, gen_p, mism, err_n;
  word_t src_w, tx_w;
  logic  src_gen;

  parity_xcvr_route u_route (
    .clk(clk), .rst_n(rst_n), .drv_a_n(drv_a_n), .drv_b_n(drv_b_n),
    .dir_ab(dir_ab), .dir_ba(dir_ba), .clash(clash)
  );

  assign bus_in[0] = '{par: a_par_in, data: a_in};
  assign bus_in[1] = '{par: b_par_in, data: b_in};
  assign lat_en    = {lat_b_en, lat_a_en};
  assign is_src    = {dir_ba, dir_ab};
  assign is_dst    = {dir_ab, dir_ba};

  // word leaving the source register
  assign src_w       = dir_ab ? reg_q[0] : reg_q[1];
  assign src_gen     = dir_ab ? gen_p[0] : gen_p[1];
  assign tx_w.data   = src_w.data;
  assign tx_w.par    = feed_sel ? src_w.par : src_gen;

  for (genvar i = 0; i < SIDES; i++) begin : g_side
    // destination register loops back the transmitted word
    assign reg_d[i] = is_dst[i] ? tx_w : bus_in[i];

    parity_xcvr_latch u_latch (
      .clk(clk), .rst_n(rst_n), .en(lat_en[i]), .d(reg_d[i]), .q(reg_q[i])
    );

    parity_xcvr_check u_check (
      .clk(clk), .rst_n(rst_n), .w(reg_q[i]), .odd(odd_sel),
      .gen(gen_p[i]), .mismatch(mism[i])
    );

    assign err_n[i] = ~((is_src[i] | (is_dst[i] & lat_en[i])) & mism[i]);
  end

  assign a_oe      = is_dst[0];
  assign b_oe      = is_dst[1];
  assign a_out     = is_dst[0] ? tx_w.data : '0;
  assign a_par_out = is_dst[0] & tx_w.par;
  assign b_out     = is_dst[1] ? tx_w.data : '0;
  assign b_par_out = is_dst[1] & tx_w.par;
  assign err_a_n   = err_n[0];
  assign err_b_n   = err_n[1];

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_a_n && drv_b_n) |-> (!a_oe && !b_oe && err_a_n && err_b_n));
  assert_clash_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> (!a_oe && !b_oe && err_a_n && err_b_n));
  assert_gen_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe && !feed_sel) |-> (($countones({b_out, b_par_out}) % 2) == int'(odd_sel)));
  assert_dst_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe && !lat_b_en) |-> err_b_n);
  assert_single_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_oe && b_oe));
endmodule

// File: tb/tb_parity_xcvr.sv
module tb_parity_xcvr;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic drv_a_n = 1, drv_b_n = 1, feed_sel = 0, odd_sel = 0, lat_a_en = 0, lat_b_en = 0;
  logic [7:0] a_in = 0, b_in = 0;
  logic a_par_in = 0, b_par_in = 0;
  logic [7:0] a_out, b_out;
  logic a_par_out, b_par_out, a_oe, b_oe, err_a_n, err_b_n, clash;

  int checks = 0, fails = 0;
  int ra_d = 0, ra_p = 0, rb_d = 0, rb_p = 0;
  int ea_out, ea_par, ea_oe, eb_out, eb_par, eb_oe, eea, eeb, ecl;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  parity_xcvr dut (.*);

  function automatic int ones(int v);
    int c = 0;
    for (int k = 0; k < 8; k++) c += (v >> k) & 1;
    return c;
  endfunction

  function automatic int want_par(int d, int odd);
    return ((ones(d) % 2) == odd) ? 0 : 1;
  endfunction

  function automatic int word_ok(int d, int p, int odd);
    return ((ones(d) + p) % 2) == odd;
  endfunction

  task automatic chk(string tag, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0h exp %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic model_outputs();
    int ab, ba, sd, sp, tp, dd, dp, dl;
    ab = drv_a_n && !drv_b_n;
    ba = !drv_a_n && drv_b_n;
    ecl = !drv_a_n && !drv_b_n;
    ea_out = 0; ea_par = 0; eb_out = 0; eb_par = 0; eea = 1; eeb = 1;
    ea_oe = ba; eb_oe = ab;
    if (ab || ba) begin
      sd = ab ? ra_d : rb_d;  sp = ab ? ra_p : rb_p;
      dd = ab ? rb_d : ra_d;  dp = ab ? rb_p : ra_p;
      dl = ab ? lat_b_en : lat_a_en;
      tp = feed_sel ? sp : want_par(sd, odd_sel);
      if (ab) begin
        eb_out = sd; eb_par = tp;
        eea = word_ok(sd, sp, odd_sel);
        eeb = dl ? word_ok(dd, dp, odd_sel) : 1;
      end else begin
        ea_out = sd; ea_par = tp;
        eeb = word_ok(sd, sp, odd_sel);
        eea = dl ? word_ok(dd, dp, odd_sel) : 1;
      end
    end
  endtask

  task automatic compare();
    string tq, tp;
    model_outputs();
    tq = ecl ? "R9" : ((ea_oe || eb_oe) ? "R2" : "R1");
    tp = feed_sel ? "R4" : "R3";
    chk(tq, a_oe, ea_oe, "a_oe");
    chk(tq, b_oe, eb_oe, "b_oe");
    chk("R9", clash, ecl, "clash");
    chk("R2", a_out, ea_out, "a_out");
    chk("R2", b_out, eb_out, "b_out");
    chk(ea_oe ? tp : tq, a_par_out, ea_par, "a_par_out");
    chk(eb_oe ? tp : tq, b_par_out, eb_par, "b_par_out");
    chk(eb_oe ? "R7" : (ea_oe ? "R8" : tq), err_a_n, eea, "err_a_n");
    chk(ea_oe ? "R7" : (eb_oe ? "R8" : tq), err_b_n, eeb, "err_b_n");
  endtask

  task automatic model_clock();
    int ab, ba, sd, tp, na_d, na_p, nb_d, nb_p;
    ab = drv_a_n && !drv_b_n;
    ba = !drv_a_n && drv_b_n;
    sd = ab ? ra_d : rb_d;
    tp = feed_sel ? (ab ? ra_p : rb_p) : want_par(sd, odd_sel);
    na_d = ra_d; na_p = ra_p; nb_d = rb_d; nb_p = rb_p;
    if (lat_a_en) begin na_d = ba ? sd : a_in; na_p = ba ? tp : a_par_in; end
    if (lat_b_en) begin nb_d = ab ? sd : b_in; nb_p = ab ? tp : b_par_in; end
    if (!rst_n) begin na_d = 0; na_p = 0; nb_d = 0; nb_p = 0; end
    ra_d = na_d; ra_p = na_p; rb_d = nb_d; rb_p = nb_p;
  endtask

  task automatic apply(bit da, bit db, bit fs, bit od, bit la, bit lb,
                       int ai, bit ap, int bi, bit bp);
    @(negedge clk);
    drv_a_n = da; drv_b_n = db; feed_sel = fs; odd_sel = od;
    lat_a_en = la; lat_b_en = lb;
    a_in = ai[7:0]; a_par_in = ap; b_in = bi[7:0]; b_par_in = bp;
    #1 compare();
    @(posedge clk);
    model_clock();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset with loads requested, registers must stay zero
    apply(1, 0, 0, 1, 1, 1, 8'hFF, 1, 8'hAA, 1);
    chk("R10", b_out, 0, "b_out under reset");
    apply(1, 0, 0, 0, 1, 1, 8'h33, 1, 8'h11, 0);
    @(negedge clk); rst_n = 1;
    // R6: load A, then hold while pins change
    apply(1, 1, 0, 0, 1, 0, 8'h5A, 0, 0, 0);
    apply(1, 0, 0, 0, 0, 0, 8'hFF, 1, 0, 0);
    chk("R6", b_out, 8'h5A, "held data after pin change");
    // R5: word 0x07 has three ones
    apply(1, 1, 0, 0, 1, 0, 8'h07, 0, 0, 0);
    apply(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5", b_par_out, 1, "even parity of 07");
    apply(1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R5", b_par_out, 0, "odd parity of 07");
    // R4 and R7: bad parity passed through, loopback into B, R8 flags it
    apply(1, 1, 1, 0, 1, 0, 8'h01, 0, 0, 0);
    apply(1, 0, 1, 0, 0, 1, 0, 0, 0, 0);
    chk("R7", err_a_n, 0, "source flag on bad word");
    apply(1, 0, 1, 0, 0, 1, 0, 0, 0, 0);
    chk("R8", err_b_n, 0, "looped bad word");
    apply(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R8", err_b_n, 1, "dest flag with latch off");
    // B to A direction, generate and feed-through
    apply(1, 1, 0, 0, 0, 1, 0, 0, 8'hC3, 0);
    apply(0, 1, 0, 1, 1, 0, 0, 0, 0, 0);
    apply(0, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    // R9 and R1
    apply(0, 0, 0, 0, 1, 1, 8'h12, 1, 8'h34, 0);
    chk("R9", clash, 1, "clash");
    apply(1, 1, 1, 1, 1, 1, 8'h12, 1, 8'h34, 0);
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom;
      apply(r[0] | r[1], !r[0] | (r[1] & r[2] & r[3]), r[4], r[5], r[6] | r[7], r[8] | r[9],
            $urandom_range(255), r[10], $urandom_range(255), r[11]);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule